// File: doc/BRIEF.md
# Dual-Core Sequential-Line Prefetcher

This block sits beside a second-level cache that two cores share. It watches the request stream, takes the line address of each request by dropping the six byte-offset bits of a 64-byte line, and follows each core's recent lines on their own. A core that has stepped forward by exactly one line twice in a row is treated as streaming. From then on, every further one-line step from that core produces a prefetch for the line after the one just requested.

Each core has a tracker built as a four-state machine. `TRK_EMPTY` means no line has been recorded yet. `TRK_BASE` means a line is recorded and no forward step has been seen. `TRK_STEP1` means one forward step has been seen. `TRK_STREAM` means two or more forward steps have been seen.

The transitions are few. A request from `TRK_EMPTY` goes to `TRK_BASE`. A step to the recorded line plus one moves `TRK_BASE` to `TRK_STEP1`, and moves `TRK_STEP1` to `TRK_STREAM`, which fires a prefetch. The same step keeps `TRK_STREAM` in place and fires again. A repeat of the recorded line leaves every state unchanged. Any other line sends the tracker back to `TRK_BASE` with that line recorded.

A fired prefetch goes into a one-entry slot for that core. A shared issue stage moves slots into a registered output that uses a valid/ready handshake, and core 0 is served first.

Top module: `l2_nextline_pf`

## Requirements
- R1: The line address is the request address shifted right by 6. Two requests that differ only in bits [5:0] count as the same line.
- R2: After reset, a core's first valid request only records its line and never produces a prefetch.
- R3: Two successive one-line forward steps from one core produce a prefetch of the newest line plus one. A single step produces nothing. The prefetch is on the output after the second clock edge following the triggering request.
- R4: While streaming, each further one-line step produces a new prefetch one line ahead. A repeated request to the recorded line produces none and does not end the stream.
- R5: A request to any line that is neither the recorded line nor that line plus one clears the step history. Two new forward steps are then needed before the next prefetch.
- R6: The two cores are tracked independently. Requests tagged with one core id never change the other core's detection.
- R7: Address and core id are ignored in cycles where the request valid is low.
- R8: While the output is valid and ready is low, the output line stays unchanged. Each accepted handshake delivers exactly one prefetch.
- R9: When both cores have a prefetch waiting as the output frees up, core 0's prefetch is delivered first and core 1's one cycle later.
- R10: Each core holds at most one undelivered prefetch. A newer prefetch from the same core replaces an older one that has not yet reached the output.
- R11: Out of reset, the prefetch valid output is low.
- R12: Line arithmetic wraps at the line-address width. The top line followed by line 0 counts as a forward step, and the prefetch after the top line is line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_core | input | 1 | Core that issued the request |
| req_addr | input | 16 | Byte address of the request |
| pf_ready | input | 1 | Downstream accepts the prefetch this cycle |
| pf_valid | output | 1 | A prefetch line is offered |
| pf_line | output | 10 | Line address to prefetch |

## Verification
A tracker in the wrong state shows up as a prefetch that is missing, extra or off by one line. That error appears two edges after the request that exposes it. Each streaming step therefore tests the state left by the step before it.

A sweep of all four-step sequences built from repeat, forward and jump moves, with requests from the two cores interleaved, brings every state transition to the output within a few cycles of its cause. A priority or slot-overwrite fault shows up only as a wrong delivery order under back-pressure, so stalled scenarios check the exact order of delivered lines once ready returns.

// File: rtl/nlp_pkg.sv
`timescale 1ns/1ps
package nlp_pkg;

    typedef enum logic [1:0] {
        TRK_EMPTY  = 2'd0,
        TRK_BASE   = 2'd1,
        TRK_STEP1  = 2'd2,
        TRK_STREAM = 2'd3
    } trk_state_e;

endpackage

// File: rtl/nlp_tracker.sv
`timescale 1ns/1ps
module nlp_tracker
    import nlp_pkg::*;
#(
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic [LINE_W-1:0] line,
    input  logic              grant,
    output logic              slot_v,
    output logic [LINE_W-1:0] slot_line
);

    trk_state_e        state, state_n;
    logic [LINE_W-1:0] last_line;
    logic [LINE_W-1:0] succ_line;
    logic              take;
    logic              fire;

    assign succ_line = last_line + LINE_W'(1);

    always_comb begin
        state_n = state;
        take    = 1'b0;
        fire    = 1'b0;
        if (hit) begin
            unique case (state)
                TRK_EMPTY: begin
                    state_n = TRK_BASE;
                    take    = 1'b1;
                end
                TRK_BASE: begin
                    if (line != last_line) begin
                        take    = 1'b1;
                        state_n = (line == succ_line) ? TRK_STEP1 : TRK_BASE;
                    end
                end
                TRK_STEP1: begin
                    if (line != last_line) begin
                        take = 1'b1;
                        if (line == succ_line) begin
                            state_n = TRK_STREAM;
                            fire    = 1'b1;
                        end else begin
                            state_n = TRK_BASE;
                        end
                    end
                end
                TRK_STREAM: begin
                    if (line != last_line) begin
                        take = 1'b1;
                        if (line == succ_line) begin
                            fire = 1'b1;
                        end else begin
                            state_n = TRK_BASE;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= TRK_EMPTY;
            last_line <= '0;
        end else begin
            state <= state_n;
            if (take) begin
                last_line <= line;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_v    <= 1'b0;
            slot_line <= '0;
        end else if (fire) begin
            slot_v    <= 1'b1;
            slot_line <= line + LINE_W'(1);
        end else if (grant) begin
            slot_v    <= 1'b0;
        end
    end

    // R3: a slot only fills after a step taken from STEP1 or STREAM
    p_fill_from_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slot_v) |-> ($past(state) == TRK_STEP1 || $past(state) == TRK_STREAM));

    // R10: an undelivered prefetch is never lost without a grant
    p_slot_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_v && !grant) |=> slot_v);

endmodule

// File: rtl/nlp_issue.sv
`timescale 1ns/1ps
module nlp_issue #(
    parameter int N_SRC  = 2,
    parameter int LINE_W = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_SRC-1:0]              pend_v,
    input  logic [N_SRC-1:0][LINE_W-1:0]  pend_line,
    input  logic                          pf_ready,
    output logic [N_SRC-1:0]              grant,
    output logic                          pf_valid,
    output logic [LINE_W-1:0]             pf_line
);

    logic              out_free;
    logic              pick_v;
    logic [LINE_W-1:0] pick_line;

    assign out_free = !pf_valid || pf_ready;

    always_comb begin
        grant     = '0;
        pick_v    = 1'b0;
        pick_line = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (pend_v[i]) begin
                pick_v    = 1'b1;
                pick_line = pend_line[i];
                grant     = '0;
                grant[i]  = out_free;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_valid <= 1'b0;
            pf_line  <= '0;
        end else if (out_free) begin
            pf_valid <= pick_v;
            if (pick_v) begin
                pf_line <= pick_line;
            end
        end
    end

    // R8: a stalled offer stays put
    p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_line)));

    // R9: lowest core index wins when both wait
    p_core0_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_free && pend_v[0] && pend_v[N_SRC-1]) |=> (pf_line == $past(pend_line[0])));

    // R11: no offer appears without a waiting slot
    p_no_spurious_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pf_valid) |-> $past(|pend_v));

endmodule

// File: rtl/l2_nextline_pf.sv
`timescale 1ns/1ps
module l2_nextline_pf #(
    parameter int N_CORES  = 2,
    parameter int ADDR_W   = 16,
    parameter int OFFSET_W = 6,
    localparam int LINE_W  = ADDR_W - OFFSET_W,
    localparam int CORE_W  = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CORE_W-1:0] req_core,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              pf_ready,
    output logic              pf_valid,
    output logic [LINE_W-1:0] pf_line
);

    logic [LINE_W-1:0]               req_line;
    logic [N_CORES-1:0]              hit;
    logic [N_CORES-1:0]              grant;
    logic [N_CORES-1:0]              pend_v;
    logic [N_CORES-1:0][LINE_W-1:0]  pend_line;

    assign req_line = req_addr[ADDR_W-1:OFFSET_W];

    for (genvar g = 0; g < N_CORES; g++) begin : g_core
        assign hit[g] = req_valid && (req_core == CORE_W'(g));

        nlp_tracker #(
            .LINE_W (LINE_W)
        ) u_trk (
            .clk       (clk),
            .rst_n     (rst_n),
            .hit       (hit[g]),
            .line      (req_line),
            .grant     (grant[g]),
            .slot_v    (pend_v[g]),
            .slot_line (pend_line[g])
        );
    end

    nlp_issue #(
        .N_SRC  (N_CORES),
        .LINE_W (LINE_W)
    ) u_issue (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_v    (pend_v),
        .pend_line (pend_line),
        .pf_ready  (pf_ready),
        .grant     (grant),
        .pf_valid  (pf_valid),
        .pf_line   (pf_line)
    );

endmodule

// File: tb/l2_nextline_pf_bench.sv
`timescale 1ns/1ps
module l2_nextline_pf_bench;

    localparam int LW   = 10;
    localparam int MASK = (1 << LW) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_core = 1'b0;
    logic [15:0] req_addr = '0;
    logic        pf_ready = 1'b1;
    logic        pf_valid;
    logic [9:0]  pf_line;

    int n_checks = 0;
    int n_fails  = 0;
    int m_last [2];
    int m_cnt  [2];
    bit m_have [2];
    int exp_q [$];
    string cur_tag = "R3";

    always #2.5 clk = ~clk;

    l2_nextline_pf u_l2_nextline_pf (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_core  (req_core),
        .req_addr  (req_addr),
        .pf_ready  (pf_ready),
        .pf_valid  (pf_valid),
        .pf_line   (pf_line)
    );

    task automatic check(bit ok, string tag, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int c = 0; c < 2; c++) begin
            m_have[c] = 1'b0;
            m_cnt[c]  = 0;
            m_last[c] = 0;
        end
        exp_q.delete();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        model_clear();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // drive one valid request at a negedge; returns after the sampling edge
    task automatic send(int core, int line, int off, bit auto_push, output bit fired, output int pline);
        int ln;
        ln = line & MASK;
        fired = 1'b0;
        pline = 0;
        if (!m_have[core]) begin
            m_have[core] = 1'b1;
            m_cnt[core]  = 0;
            m_last[core] = ln;
        end else if (ln == m_last[core]) begin
        end else if (ln == ((m_last[core] + 1) & MASK)) begin
            m_cnt[core]  = (m_cnt[core] == 0) ? 1 : 2;
            m_last[core] = ln;
            if (m_cnt[core] == 2) begin
                fired = 1'b1;
                pline = (ln + 1) & MASK;
            end
        end else begin
            m_cnt[core]  = 0;
            m_last[core] = ln;
        end
        if (fired && auto_push) exp_q.push_back(pline);
        req_valid = 1'b1;
        req_core  = core[0];
        req_addr  = {ln[9:0], off[5:0]};
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // delivery monitor: compare each accepted prefetch in order
    always @(negedge clk) begin
        #1;
        if (rst_n && pf_valid && pf_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, {cur_tag, " unexpected prefetch"}, pf_line, -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                check(pf_line == e[9:0], cur_tag, pf_line, e);
            end
        end
    end

    initial begin
        fork
            begin
                repeat (190000) @(posedge clk);
                check(1'b0, "watchdog", 0, 1);
                $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
                $finish;
            end
        join_none
    end

    initial begin
        bit f;
        int pl;
        int v;

        // R11: reset state
        do_reset();
        #1;
        check(pf_valid == 1'b0, "R11 reset valid", pf_valid, 0);
        @(negedge clk);

        // R2 R3 R1: latency and offset independence
        cur_tag = "R3";
        send(0, 300, 5, 1, f, pl);
        send(0, 300, 63, 1, f, pl);          // R1: same line, other offset
        send(0, 301, 0, 1, f, pl);           // R2 then one step: nothing
        #1; check(pf_valid == 1'b0, "R3 single step", pf_valid, 0);
        @(negedge clk);
        send(0, 302, 17, 1, f, pl);
        check(f == 1'b1, "R3 model fire", f, 1);
        #1; check(pf_valid == 1'b0, "R3 latency early", pf_valid, 0);
        @(negedge clk); #1;
        check(pf_valid == 1'b1, "R3 latency valid", pf_valid, 1);
        check(pf_line == 10'd303, "R3 line", pf_line, 303);
        idle(3);

        // R4: repeat keeps stream, step prefetches one ahead
        cur_tag = "R4";
        send(0, 302, 1, 1, f, pl);
        send(0, 303, 1, 1, f, pl);
        send(0, 303, 9, 1, f, pl);
        send(0, 304, 2, 1, f, pl);
        idle(4);

        // R5: jump clears history
        cur_tag = "R5";
        send(0, 600, 0, 1, f, pl);
        send(0, 601, 0, 1, f, pl);
        send(0, 650, 0, 1, f, pl);
        send(0, 651, 0, 1, f, pl);
        send(0, 652, 0, 1, f, pl);
        idle(4);

        // R7: invalid cycles are ignored
        cur_tag = "R7";
        send(1, 50, 0, 1, f, pl);
        req_valid = 1'b0; req_core = 1'b1; req_addr = {10'd51, 6'd0};
        @(negedge clk);
        req_addr = {10'd52, 6'd0};
        @(negedge clk);
        send(1, 51, 0, 1, f, pl);
        send(1, 52, 0, 1, f, pl);
        idle(4);

        // R12: wrap at top line
        cur_tag = "R12";
        send(1, 1022, 0, 1, f, pl);
        send(1, 1023, 0, 1, f, pl);
        send(1, 0, 0, 1, f, pl);
        check(pl == 1, "R12 model wrap", pl, 1);
        send(1, 1, 0, 1, f, pl);
        idle(4);
        check(exp_q.size() == 0, "R4 drained", exp_q.size(), 0);

        // R8 R9: stall, then core 0 ahead of core 1
        do_reset();
        cur_tag = "R9";
        pf_ready = 1'b0;
        send(1, 100, 0, 0, f, pl);
        send(1, 101, 0, 0, f, pl);
        send(1, 102, 0, 0, f, pl);           // A = 103
        send(1, 103, 0, 0, f, pl);           // C = 104 waits in core 1 slot
        send(0, 200, 0, 0, f, pl);
        send(0, 201, 0, 0, f, pl);
        send(0, 202, 0, 0, f, pl);           // B = 203 waits in core 0 slot
        for (int k = 0; k < 4; k++) begin
            #1;
            check(pf_valid && pf_line == 10'd103, "R8 hold", pf_line, 103);
            @(negedge clk);
        end
        exp_q.push_back(103);
        exp_q.push_back(203);
        exp_q.push_back(104);
        pf_ready = 1'b1;
        idle(5);
        check(exp_q.size() == 0, "R9 order drained", exp_q.size(), 0);

        // R10: newer prefetch replaces an undelivered one
        do_reset();
        cur_tag = "R10";
        pf_ready = 1'b0;
        send(0, 10, 0, 0, f, pl);
        send(0, 11, 0, 0, f, pl);
        send(0, 12, 0, 0, f, pl);            // 13
        send(0, 13, 0, 0, f, pl);            // 14
        send(0, 14, 0, 0, f, pl);            // 15 replaces 14
        idle(2);
        exp_q.push_back(13);
        exp_q.push_back(15);
        pf_ready = 1'b1;
        idle(5);
        check(exp_q.size() == 0, "R10 drained", exp_q.size(), 0);

        // R6 R5 R4: sweep of all four-move sequences, two cores interleaved
        do_reset();
        cur_tag = "R6";
        for (int s = 0; s < 256; s++) begin
            int ln [2];
            ln[0] = (s * 37) & MASK;
            ln[1] = (s * 37 + 500) & MASK;
            for (int j = 0; j < 4; j++) begin
                for (int c = 0; c < 2; c++) begin
                    int d;
                    d = ((s ^ (c * 8'h55)) >> (2 * j)) & 3;
                    ln[c] = (ln[c] + ((d == 0) ? 0 : (d == 3) ? 5 : 1)) & MASK;
                    send(c, ln[c], (s + j) & 63, 1, f, pl);
                end
            end
        end
        idle(6);
        check(exp_q.size() == 0, "R6 sweep drained", exp_q.size(), 0);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule